// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running nanosecond time of day. On every clock edge it adds a programmable unsigned increment to a wide accumulator. The top 44 bits of the accumulator are the integer nanosecond count, and the 29 bits below them are a binary fraction of a nanosecond. The nominal increment 0x80000000 carries 3 integer bits and 29 fractional bits, so it advances the count by exactly 4 ns per clock. Raising or lowering the increment by one LSB trims the rate by about 0.466 ppb, and trims of ±50,000,000 ppb still fit in 32 bits.

Software reaches the counter through a small single-cycle register port with four 32-bit words. The integer time is split into three fields that can be read and loaded separately. The top field is read in the low byte of its word but loaded from the second byte. Writing a zero increment freezes the time, so software can load a new value safely. Writing a nonzero increment lets the count run on from the held value.

Top module: `tnco_timer`

## Requirements
- R1: The word index `reg_addr` selects the register: 0 is the low field (byte offset 0x00), 1 is the main field (0x04), 2 is the top field (0x08) and 3 is the increment (0x0C).
- R2: The integer count is 44 bits wide and rolls over from 0xFFF_FFFF_FFFF to zero with no other effect.
- R3: A read returns bits [3:0] of the count in bits [3:0] of word 0, bits [35:4] as the whole of word 1, and bits [43:36] in bits [7:0] of word 2. All other read bits are zero.
- R4: A write to word 2 loads the top field from write bits [15:8]. A write to word 0 loads the low field from write bits [3:0]. All other write bits of these two words are ignored.
- R5: Each clock adds the increment to the accumulator, which has 29 fraction bits. The carry out of the fraction advances the count, so 0x20000000 gives 1 ns per clock and 0x10000000 gives one nanosecond every second clock.
- R6: While the increment is zero the count holds. Writing a nonzero increment makes it advance again from the held value on the next clock.
- R7: Reset clears the count, the fraction and the read data, and loads the increment with 0x80000000. Once reset is released, the count advances 4 ns per clock. Asserting reset clears the read data at once.
- R8: Read data is registered. After a clock edge, `reg_rdata` shows the register that `reg_addr` selected, with its value as it was just before that edge.
- R9: A field write replaces only that field in the cycle it is made, even if a carry from the increment reaches the same field. The fraction is never replaced by a write and keeps accumulating.
- R10: The increment reads back as the last value written to word 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 2 | Word index of the register being accessed |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |

## Verification
The count is first frozen with a zero increment, so that field loads and field reads can be compared exactly. Write data with extra bits set shows whether the top field is taken from the second byte and the low field only from the low nibble. Whole-nanosecond, half-nanosecond and nominal increments are then applied. These separate a correct fraction carry from a design that ignores the fraction or adds the increment to the integer part. Loads of all ones followed by a run of 1 ns steps separate a clean 44-bit rollover from carries that stop at a field boundary. Loading the low field as 0xF while the count runs shows that the write wins over the carry in the same cycle. A low-field load made while the fraction is at one half shows that the fraction survives the load.

// File: rtl/tnco_pkg.sv
package tnco_pkg;
  localparam int TNCO_NS_W      = 44;
  localparam int TNCO_FRAC_W    = 29;
  localparam int TNCO_INC_W     = 32;
  localparam int TNCO_WORD_W    = 32;
  localparam int TNCO_LOW_W     = 4;
  localparam int TNCO_TOP_W     = 8;
  localparam int TNCO_TOP_WR_LSB = 8;
  localparam logic [31:0] TNCO_INC_NOMINAL = 32'h8000_0000;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_MAIN = 2'd1,
    REG_TOP  = 2'd2,
    REG_INC  = 2'd3
  } tnco_reg_e;
endpackage

// File: rtl/tnco_accum.sv
module tnco_accum
  import tnco_pkg::*;
#(
  parameter int NS_W   = TNCO_NS_W,
  parameter int FRAC_W = TNCO_FRAC_W,
  parameter int INC_W  = TNCO_INC_W,
  parameter int LOW_W  = TNCO_LOW_W,
  parameter int TOP_W  = TNCO_TOP_W,
  localparam int MAIN_W = NS_W - LOW_W - TOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              wr_low_i,
  input  logic              wr_main_i,
  input  logic              wr_top_i,
  input  logic [LOW_W-1:0]  low_wdata_i,
  input  logic [MAIN_W-1:0] main_wdata_i,
  input  logic [TOP_W-1:0]  top_wdata_i,
  output logic [NS_W-1:0]   ns_o
);
  localparam int ACC_W    = NS_W + FRAC_W;
  localparam int MAIN_LSB = LOW_W;
  localparam int TOP_LSB  = LOW_W + MAIN_W;
  localparam logic [NS_W-1:0] STEP_MAX = NS_W'(1) << (INC_W - FRAC_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] acc_d;
  logic             any_wr;
  logic             acc_en;

  // next state: add, then let field writes override their slices
  always_comb begin
    any_wr  = wr_low_i | wr_main_i | wr_top_i;
    acc_en  = (inc_i != '0) | any_wr;
    acc_sum = acc_q + ACC_W'(inc_i);
    acc_d   = acc_sum;
    if (wr_low_i)  acc_d[FRAC_W + 0        +: LOW_W]  = low_wdata_i;
    if (wr_main_i) acc_d[FRAC_W + MAIN_LSB +: MAIN_W] = main_wdata_i;
    if (wr_top_i)  acc_d[FRAC_W + TOP_LSB  +: TOP_W]  = top_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign ns_o = acc_q[ACC_W-1:FRAC_W];

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == '0 && !any_wr) |=> $stable(ns_o)); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_wr) |=> ((ns_o - $past(ns_o)) <= STEP_MAX)); // R5

  AST_LOW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low_i |=> (ns_o[LOW_W-1:0] == $past(low_wdata_i))); // R9

  AST_MAIN_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main_i |=> (ns_o[MAIN_LSB +: MAIN_W] == $past(main_wdata_i))); // R9

  AST_TOP_WRITE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_top_i |=> (ns_o[TOP_LSB +: TOP_W] == $past(top_wdata_i))); // R4
endmodule

// File: rtl/tnco_regs.sv
module tnco_regs
  import tnco_pkg::*;
#(
  parameter int NS_W   = TNCO_NS_W,
  parameter int INC_W  = TNCO_INC_W,
  parameter int WORD_W = TNCO_WORD_W,
  parameter int LOW_W  = TNCO_LOW_W,
  parameter int TOP_W  = TNCO_TOP_W,
  parameter int TOP_WR_LSB = TNCO_TOP_WR_LSB,
  parameter logic [INC_W-1:0] INC_RESET = INC_W'(TNCO_INC_NOMINAL),
  localparam int MAIN_W = NS_W - LOW_W - TOP_W,
  localparam int NREG   = 4,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NS_W-1:0]   ns_i,
  output logic              wr_low_o,
  output logic              wr_main_o,
  output logic              wr_top_o,
  output logic [LOW_W-1:0]  low_wdata_o,
  output logic [MAIN_W-1:0] main_wdata_o,
  output logic [TOP_W-1:0]  top_wdata_o,
  output logic [INC_W-1:0]  inc_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [NREG-1:0]   hit;
  logic [INC_W-1:0]  inc_q;
  logic [INC_W-1:0]  inc_d;
  logic [WORD_W-1:0] rd_d;
  logic [WORD_W-1:0] rd_q;

  for (genvar g = 0; g < NREG; g++) begin : g_decode
    assign hit[g] = we_i && (addr_i == ADDR_W'(g));
  end

  assign wr_low_o     = hit[REG_LOW];
  assign wr_main_o    = hit[REG_MAIN];
  assign wr_top_o     = hit[REG_TOP];
  assign low_wdata_o  = wdata_i[LOW_W-1:0];
  assign main_wdata_o = wdata_i[MAIN_W-1:0];
  assign top_wdata_o  = wdata_i[TOP_WR_LSB +: TOP_W];

  always_comb begin
    inc_d = inc_q;
    if (hit[REG_INC]) inc_d = INC_W'(wdata_i);
  end

  always_comb begin
    unique case (addr_i)
      REG_LOW:  rd_d = WORD_W'(ns_i[LOW_W-1:0]);
      REG_MAIN: rd_d = WORD_W'(ns_i[LOW_W +: MAIN_W]);
      REG_TOP:  rd_d = WORD_W'(ns_i[NS_W-1 -: TOP_W]);
      default:  rd_d = WORD_W'(inc_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= INC_RESET;
      rd_q  <= '0;
    end else begin
      inc_q <= inc_d;
      rd_q  <= rd_d;
    end
  end

  assign inc_o   = inc_q;
  assign rdata_o = rd_q;

  AST_TOP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == REG_TOP) |=> (rdata_o[WORD_W-1:TOP_W] == '0)); // R3

  AST_INC_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == REG_INC) |=> (inc_o == INC_W'($past(wdata_i)))); // R10

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_low_o, wr_main_o, wr_top_o})); // R1
endmodule

// File: rtl/tnco_timer.sv
module tnco_timer
  import tnco_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int MAIN_W = TNCO_NS_W - TNCO_LOW_W - TNCO_TOP_W;

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    wr_low;
  logic                    wr_main;
  logic                    wr_top;
  logic [TNCO_LOW_W-1:0]   low_wdata;
  logic [MAIN_W-1:0]       main_wdata;
  logic [TNCO_TOP_W-1:0]   top_wdata;
  logic [TNCO_INC_W-1:0]   inc;
  logic [TNCO_NS_W-1:0]    ns;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tnco_regs #(
    .NS_W(TNCO_NS_W), .INC_W(TNCO_INC_W), .WORD_W(TNCO_WORD_W),
    .LOW_W(TNCO_LOW_W), .TOP_W(TNCO_TOP_W), .TOP_WR_LSB(TNCO_TOP_WR_LSB),
    .INC_RESET(TNCO_INC_NOMINAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .addr_i(reg_addr), .we_i(reg_we), .wdata_i(reg_wdata), .ns_i(ns),
    .wr_low_o(wr_low), .wr_main_o(wr_main), .wr_top_o(wr_top),
    .low_wdata_o(low_wdata), .main_wdata_o(main_wdata), .top_wdata_o(top_wdata),
    .inc_o(inc), .rdata_o(reg_rdata)
  );

  tnco_accum #(
    .NS_W(TNCO_NS_W), .FRAC_W(TNCO_FRAC_W), .INC_W(TNCO_INC_W),
    .LOW_W(TNCO_LOW_W), .TOP_W(TNCO_TOP_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_int_n), .inc_i(inc),
    .wr_low_i(wr_low), .wr_main_i(wr_main), .wr_top_i(wr_top),
    .low_wdata_i(low_wdata), .main_wdata_i(main_wdata), .top_wdata_i(top_wdata),
    .ns_o(ns)
  );

  AST_RESET_CLEARS_RDATA: assert property (@(posedge clk)
    (!rst_int_n) |-> (reg_rdata == '0)); // R7
endmodule

// File: tb/test_tnco_timer.sv
module test_tnco_timer;
  localparam int  NV       = 35;
  localparam time TCLK     = 8ns;
  localparam int  WD_LIMIT = 20000;

  typedef struct packed {
    logic [1:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // addr: 0 low, 1 main, 2 top, 3 increment
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b1, 32'h0000_0000, 1'b0, 32'h0, 8'd6},   // R6 freeze
    '{2'd0, 1'b1, 32'h0ABC_DEF5, 1'b0, 32'h0, 8'd4},   // R4 low nibble only
    '{2'd1, 1'b1, 32'h1234_5678, 1'b0, 32'h0, 8'd1},   // R1
    '{2'd2, 1'b1, 32'h0000_A5C3, 1'b0, 32'h0, 8'd4},   // R4 top from [15:8]
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0005, 8'd4}, // R4
    '{2'd1, 1'b0, 32'h0,         1'b1, 32'h1234_5678, 8'd3}, // R3
    '{2'd2, 1'b0, 32'h0,         1'b1, 32'h0000_00A5, 8'd4}, // R4
    '{2'd3, 1'b0, 32'h0,         1'b1, 32'h0000_0000, 8'd10}, // R10
    '{2'd3, 1'b1, 32'h2000_0000, 1'b0, 32'h0, 8'd6},   // R6 resume
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0005, 8'd6}, // R6
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0006, 8'd5}, // R5
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0007, 8'd8}, // R8
    '{2'd0, 1'b1, 32'h0000_000F, 1'b0, 32'h0, 8'd9},   // R9
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_000F, 8'd9}, // R9 write beats carry
    '{2'd1, 1'b0, 32'h0,         1'b1, 32'h1234_5679, 8'd5}, // R5 carry into main
    '{2'd3, 1'b1, 32'h0000_0000, 1'b0, 32'h0, 8'd6},
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0002, 8'd6}, // R6 held
    '{2'd1, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 8'd2},
    '{2'd2, 1'b1, 32'h0000_FF00, 1'b0, 32'h0, 8'd2},
    '{2'd0, 1'b1, 32'h0000_000F, 1'b0, 32'h0, 8'd2},
    '{2'd3, 1'b1, 32'h2000_0000, 1'b0, 32'h0, 8'd2},
    '{2'd2, 1'b0, 32'h0,         1'b1, 32'h0000_00FF, 8'd3}, // R3
    '{2'd1, 1'b0, 32'h0,         1'b1, 32'h0000_0000, 8'd2}, // R2 rollover
    '{2'd2, 1'b0, 32'h0,         1'b1, 32'h0000_0000, 8'd2}, // R2
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0002, 8'd2}, // R2
    '{2'd3, 1'b1, 32'h1000_0000, 1'b0, 32'h0, 8'd5},
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0004, 8'd5}, // R5 half ns
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0004, 8'd5},
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0005, 8'd5},
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0005, 8'd5},
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0006, 8'd5},
    '{2'd3, 1'b0, 32'h0,         1'b1, 32'h1000_0000, 8'd10}, // R10
    '{2'd0, 1'b1, 32'h0000_0008, 1'b0, 32'h0, 8'd9},
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0008, 8'd9}, // R9
    '{2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0009, 8'd9}  // R9 fraction kept
  };

  logic        clk;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_vec;
  int n_bad;
  bit done;

  tnco_timer i_tnco_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] exp);
    n_vec++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL R%0d: rdata=%h expected=%h at %0t", req, reg_rdata, exp, $time);
    end
  endtask

  initial begin
    for (int k = 0; k < WD_LIMIT; k++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_addr = 2'd0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #2 check(7, 32'h0);                       // R7 reset state
    @(negedge clk) rst_n = 1'b1;
    // two sync stages, then counting at 4 ns per clock
    begin
      logic [31:0] seq [6] = '{32'd0, 32'd0, 32'd0, 32'd4, 32'd8, 32'd12};
      for (int k = 0; k < 6; k++) begin
        @(posedge clk); #2 check(7, seq[k]);  // R7 nominal rate
      end
    end
    @(negedge clk) reg_addr = 2'd3;
    @(posedge clk); #2 check(7, 32'h8000_0000); // R7 increment reset value

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_addr  = VECS[i].addr;
      reg_we    = VECS[i].we;
      reg_wdata = VECS[i].wdata;
      @(posedge clk);
      #2 if (VECS[i].chk) check(int'(VECS[i].req), VECS[i].exp);
    end
    @(negedge clk) reg_we = 1'b0; reg_addr = 2'd1;

    // asynchronous reset mid-run clears read data at once
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1 check(7, 32'h0);                       // R7 async clear
    @(negedge clk) rst_n = 1'b1; reg_addr = 2'd3;
    repeat (3) @(posedge clk);
    #2 check(7, 32'h8000_0000);               // R7 increment restored

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule